// File: doc/BRIEF.md
# Over-Clock Recovery Watchdog

This block lets a system recover from an over-clock setting that makes it hang. Software programs a timeout in whole seconds and enables the watchdog. From then on the counter moves down by one on every one-second tick. Each register write reloads the counter, so a healthy system keeps it from reaching zero. If the count does reach zero, the block does three things. It drives an active-low system reset pulse. It sets a sticky status flag. It replaces the normal frequency selection with a safe code that was stored earlier. A change in the frequency setting also produces the same reset pulse, so the system restarts cleanly at the new clock.

The control byte has a fixed bit layout. Bits [3:0] hold the safe frequency code. Bit 4 enables the countdown. Writing a 1 to bit 5 clears the status flag. Bit 6 set to 1 stops frequency-change events from causing a reset pulse. Bit 7 selects where the clock generator takes its frequency: 1 means the direct divider registers, 0 means the normal select code. The count byte is an unsigned number of seconds. Its reset default is 16, and the counter starts from that value. The one-second tick comes from outside the block, and it produces no clocks of its own.

Top module: `ocrw_top`

## Requirements
- R1: After reset, `sys_rst_n` is 1, `wd_status` is 0 and `freq_ovr` is 0. `freq_sel` equals `hw_sel`, and `div_direct` equals control bit 7.
- R2: Every cycle with `reg_wr` high loads the counter with `cnt_reg` and re-arms the watchdog, whatever the enable bit is.
- R3: While control bit 4 (enable) is 0, the counter holds its value and no expiry happens, even with ticks or a zero count.
- R4: While enabled, each `sec_tick` cycle lowers the counter by one. Expiry is reached one cycle after the clock edge that takes the count from 1 to 0, so a load of N gives expiry after exactly N ticks.
- R5: A count of 0 with enable set expires in the cycle that follows the load, without any tick.
- R6: From the edge after expiry, `sys_rst_n` stays low for exactly RST_W clock cycles.
- R7: A `freq_chg` pulse gives the same RST_W-cycle low pulse unless control bit 6 is 1. It does not set the status flag. A new trigger while a pulse is running restarts the full width.
- R8: Expiry sets `wd_status`. The flag stays set until a register write with control bit 5 set to 1 clears it.
- R9: While the status flag is set, `freq_ovr` is 1 and `freq_sel` shows the safe code captured from control bits [3:0] at expiry. Changes to `hw_sel` have no effect on `freq_sel`, and `div_direct` is forced to 0. Clearing the flag restores the normal selection.
- R10: Expiry happens only once per load. Once it has fired, no further pulse comes until the next register write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-cycle pulse every second |
| cnt_reg | input | 8 | Timeout count register value (seconds) |
| ctl_reg | input | 8 | Control register value |
| reg_wr | input | 1 | Strobe: the count or control register was written |
| freq_chg | input | 1 | Strobe: the frequency setting changed |
| hw_sel | input | 4 | Normal frequency select code |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| wd_status | output | 1 | Sticky expiry flag |
| freq_ovr | output | 1 | Safe frequency override is in force |
| freq_sel | output | 4 | Frequency select code in use |
| div_direct | output | 1 | Use the direct divider registers |

## Verification
The assertions assume three things about the inputs. `sec_tick` and `freq_chg` are single-cycle strobes. `reg_wr` marks a cycle in which `cnt_reg` and `ctl_reg` already hold their new values. The control bits are meaningful in every cycle, not only during writes. The stimulus changes register values only together with a `reg_wr` pulse, except where a scenario deliberately moves `hw_sel` to show that it is ignored. Every strobe is raised for exactly one clock.

// File: rtl/ocrw_pkg.sv
package ocrw_pkg;

  localparam int SEL_W = 4;

  // control byte layout
  typedef struct packed {
    logic             direct;   // [7] take frequency from divider registers
    logic             chg_mask; // [6] suppress reset on frequency change
    logic             clr_stat; // [5] write one to clear status
    logic             enable;   // [4] countdown enable
    logic [SEL_W-1:0] safe;     // [3:0] safe frequency code
  } ctl_t;

  // next counter value: load beats decrement, decrement only when enabled
  function automatic int unsigned next_count(input int unsigned cur,
                                             input int unsigned ld_val,
                                             input logic ld,
                                             input logic en,
                                             input logic tick);
    if (ld)                       return ld_val;
    if (en && tick && cur != 0)   return cur - 1;
    return cur;
  endfunction

  // reset pulse length counter: trigger restarts full width
  function automatic int unsigned next_pulse(input int unsigned cur,
                                             input logic trig,
                                             input int unsigned width);
    if (trig)     return width;
    if (cur != 0) return cur - 1;
    return 0;
  endfunction

  // frequency code in use
  function automatic logic [SEL_W-1:0] pick_sel(input logic ovr,
                                                input logic [SEL_W-1:0] safe,
                                                input logic [SEL_W-1:0] hw);
    return ovr ? safe : hw;
  endfunction

endpackage

// File: rtl/ocrw_counter.sv
module ocrw_counter #(
  parameter int          CNT_W     = 8,
  parameter int unsigned DEF_COUNT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             en,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  import ocrw_pkg::*;

  logic armed_q;
  logic at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = en & armed_q & ~ld & at_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(DEF_COUNT);
      armed_q <= 1'b1;
    end else begin
      cnt_q <= CNT_W'(next_count(int'(cnt_q), int'(ld_val), ld, en, tick));
      if (ld)          armed_q <= 1'b1;
      else if (expire) armed_q <= 1'b0;
    end
  end

  AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> cnt_q == $past(ld_val)); // R2
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt_q)); // R3
  AST_TICK_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && !ld && !at_zero) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_EXP_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !expire); // R10

endmodule

// File: rtl/ocrw_pulse.sv
module ocrw_pulse #(
  parameter int RST_W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic sys_rst_n
);
  import ocrw_pkg::*;

  localparam int PW_W = $clog2(RST_W + 1);

  logic [PW_W-1:0] pcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt_q <= '0;
    else        pcnt_q <= PW_W'(next_pulse(int'(pcnt_q), trig, RST_W));
  end

  assign sys_rst_n = (pcnt_q == '0);

  AST_PULSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (pcnt_q == PW_W'(RST_W)) && !sys_rst_n); // R6
  AST_PULSE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && pcnt_q != '0) |=> pcnt_q == $past(pcnt_q) - 1'b1); // R6
  AST_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && sys_rst_n) |=> sys_rst_n); // R7

endmodule

// File: rtl/ocrw_freq_ovr.sv
module ocrw_freq_ovr
  import ocrw_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             expire,
  input  logic             clr,
  input  logic [SEL_W-1:0] safe_code,
  input  logic [SEL_W-1:0] hw_sel,
  input  logic             direct_req,
  output logic             status,
  output logic             ovr,
  output logic [SEL_W-1:0] sel_out,
  output logic             direct_out
);

  logic             trip_q;
  logic [SEL_W-1:0] safe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
      safe_q <= '0;
    end else begin
      if (expire) begin
        trip_q <= 1'b1;
        safe_q <= safe_code;
      end else if (clr) begin
        trip_q <= 1'b0;
      end
    end
  end

  assign status     = trip_q;
  assign ovr        = trip_q;
  assign sel_out    = pick_sel(trip_q, safe_q, hw_sel);
  assign direct_out = direct_req & ~trip_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !clr) |=> status); // R8
  AST_SAFE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> ovr && sel_out == $past(safe_code) && !direct_out); // R9

endmodule

// File: rtl/ocrw_top.sv
module ocrw_top #(
  parameter int          CNT_W     = 8,
  parameter int unsigned DEF_COUNT = 16,
  parameter int          RST_W     = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sec_tick,
  input  logic [CNT_W-1:0]           cnt_reg,
  input  logic [7:0]                 ctl_reg,
  input  logic                       reg_wr,
  input  logic                       freq_chg,
  input  logic [ocrw_pkg::SEL_W-1:0] hw_sel,
  output logic                       sys_rst_n,
  output logic                       wd_status,
  output logic                       freq_ovr,
  output logic [ocrw_pkg::SEL_W-1:0] freq_sel,
  output logic                       div_direct
);
  import ocrw_pkg::*;

  ctl_t ctl;
  logic expire;
  logic chg_trig;
  logic pulse_trig;
  logic stat_clr;
  logic [CNT_W-1:0] cnt_q;

  assign ctl        = ctl_t'(ctl_reg);
  assign chg_trig   = freq_chg & ~ctl.chg_mask;
  assign pulse_trig = expire | chg_trig;
  assign stat_clr   = reg_wr & ctl.clr_stat;

  ocrw_counter #(.CNT_W(CNT_W), .DEF_COUNT(DEF_COUNT)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ld(reg_wr), .ld_val(cnt_reg),
    .en(ctl.enable), .tick(sec_tick), .cnt_q(cnt_q), .expire(expire)
  );

  ocrw_pulse #(.RST_W(RST_W)) u_pls (
    .clk(clk), .rst_n(rst_n), .trig(pulse_trig), .sys_rst_n(sys_rst_n)
  );

  ocrw_freq_ovr u_ovr (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(stat_clr),
    .safe_code(ctl.safe), .hw_sel(hw_sel), .direct_req(ctl.direct),
    .status(wd_status), .ovr(freq_ovr), .sel_out(freq_sel),
    .direct_out(div_direct)
  );

  AST_EXP_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !sys_rst_n && wd_status); // R6
  AST_ZERO_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && ctl.enable && !reg_wr && !wd_status && !$past(expire))
      |-> expire); // R5
  AST_CHG_NO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_trig && !expire && !wd_status) |=> !wd_status && !sys_rst_n); // R7
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.enable |-> !expire); // R3

endmodule

// File: tb/sim_ocrw_top.sv
module sim_ocrw_top;
  localparam int RW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sec_tick = 1'b0;
  logic [7:0] cnt_reg = 8'd0;
  logic [7:0] ctl_reg = 8'h80;
  logic       reg_wr = 1'b0;
  logic       freq_chg = 1'b0;
  logic [3:0] hw_sel = 4'd5;
  logic       sys_rst_n, wd_status, freq_ovr, div_direct;
  logic [3:0] freq_sel;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ocrw_top #(.CNT_W(8), .DEF_COUNT(16), .RST_W(RW)) u0 (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cnt_reg(cnt_reg),
    .ctl_reg(ctl_reg), .reg_wr(reg_wr), .freq_chg(freq_chg), .hw_sel(hw_sel),
    .sys_rst_n(sys_rst_n), .wd_status(wd_status), .freq_ovr(freq_ovr),
    .freq_sel(freq_sel), .div_direct(div_direct)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic load(input logic [7:0] c, input logic [7:0] k);
    cnt_reg = c; ctl_reg = k; reg_wr = 1'b1;
    step();
    reg_wr = 1'b0;
  endtask

  task automatic tick();
    sec_tick = 1'b1; step(); sec_tick = 1'b0;
  endtask

  // counts low samples of the reset pulse, starting at current sample
  task automatic low_len(output int n);
    n = 0;
    for (int i = 0; i < 4 * RW && !sys_rst_n; i++) begin
      n++; step();
    end
  endtask

  task automatic t_reset();
    step(); step();
    rst_n = 1'b1;
    step();
    chk("R1 rst_n out", int'(sys_rst_n), 1);
    chk("R1 status", int'(wd_status), 0);
    chk("R1 ovr", int'(freq_ovr), 0);
    chk("R1 sel", int'(freq_sel), 5);
    chk("R1 direct", int'(div_direct), 1);
  endtask

  task automatic t_countdown();
    int n;
    load(8'd2, 8'h00);                 // disabled
    for (int i = 0; i < 5; i++) tick();
    step();
    chk("R3 no expiry when off", int'(sys_rst_n), 1);
    chk("R3 status when off", int'(wd_status), 0);
    load(8'd2, 8'h10);                 // R2 reload, enabled
    tick(); step();
    chk("R4 after 1 of 2 ticks", int'(sys_rst_n), 1);
    tick();
    chk("R4 not before expiry edge", int'(sys_rst_n), 1);
    step();
    chk("R6 pulse starts", int'(sys_rst_n), 0);
    chk("R8 status set", int'(wd_status), 1);
    low_len(n);
    chk("R6 pulse width", n, RW);
    for (int i = 0; i < 6; i++) tick();
    chk("R10 no second pulse", int'(sys_rst_n), 1);
    load(8'd9, 8'h00);
    chk("R8 status sticky", int'(wd_status), 1);
    load(8'd9, 8'h20);
    chk("R8 status cleared", int'(wd_status), 0);
  endtask

  task automatic t_override();
    int n;
    hw_sel = 4'd5;
    load(8'd1, 8'h9A);
    chk("R9 direct before expiry", int'(div_direct), 1);
    tick(); step();
    chk("R9 override", int'(freq_ovr), 1);
    chk("R9 safe code", int'(freq_sel), 10);
    chk("R9 direct forced", int'(div_direct), 0);
    hw_sel = 4'd3; #1;
    chk("R9 hw ignored", int'(freq_sel), 10);
    low_len(n);
    load(8'd9, 8'hA0);
    chk("R9 restored sel", int'(freq_sel), 3);
    chk("R9 restored direct", int'(div_direct), 1);
    chk("R9 ovr off", int'(freq_ovr), 0);
  endtask

  task automatic t_zero();
    int n;
    load(8'd0, 8'h10);
    chk("R5 not yet", int'(sys_rst_n), 1);
    step();
    chk("R5 immediate expiry", int'(sys_rst_n), 0);
    low_len(n);
    load(8'd0, 8'h20);                 // clear, disabled, zero count
    for (int i = 0; i < 4; i++) step();
    chk("R3 zero while off", int'(sys_rst_n), 1);
    load(8'd1, 8'h10);                 // R2 re-arm
    tick(); step();
    chk("R2 re-armed expiry", int'(sys_rst_n), 0);
    low_len(n);
    load(8'd50, 8'h20);
  endtask

  task automatic t_freqchg();
    int n;
    freq_chg = 1'b1; step(); freq_chg = 1'b0;
    chk("R7 pulse on change", int'(sys_rst_n), 0);
    chk("R7 no status", int'(wd_status), 0);
    for (int i = 0; i < 4; i++) step();
    freq_chg = 1'b1; step(); freq_chg = 1'b0;
    low_len(n);
    chk("R7 restart width", n, RW);
    load(8'd50, 8'h40);                // mask changes
    freq_chg = 1'b1; step(); freq_chg = 1'b0;
    chk("R7 masked change", int'(sys_rst_n), 1);
  endtask

  initial begin
    t_reset();
    t_countdown();
    t_override();
    t_zero();
    t_freqchg();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule